// File: doc/BRIEF.md
# CAN Controller Mode and Interrupt Register Core

This block is the register and control core of a CAN controller with 32 mailboxes. Software reaches it over a simple 16-bit register bus with a write strobe, a word address and a combinational read port. It holds the operating-mode controls: a configuration request, a sleep request and a soft reset. It also holds the per-mailbox enable and direction settings, the transmit requests, the completion and receive flags, the interrupt masks and a global event status word. It drives three interrupt lines: receive, transmit and error.

The bit-level protocol engine is not part of this block. It sits on the other side of a narrow stub interface. The engine answers the configuration and sleep requests with acknowledge inputs, reports "frame received on mailbox N" and "transmission finished on mailbox N" as single-cycle strobes with a mailbox index, and pulses error events into the global status word. The core presents the pending transmit requests to the engine as a 32-bit vector.

Top module: `can_ctrl_core`

Register word addresses: 0 control, 1 status, 2 wake, 3/4 enable low/high, 5/6 direction low/high, 7/8 transmit request low/high, 9/10 transmit done low/high, 11/12 receive flags low/high, 13/14 mailbox interrupt mask low/high, 15 global status, 16 global mask. In every low/high pair, the low word covers mailboxes 0–15 and the high word covers 16–31, with bit k of a word standing for mailbox (16·half + k).

## Requirements
- R1: After synchronous reset every register reads 0, and cfg_req_o, slp_req_o, tx_req_o and all three interrupt lines are low.
- R2: Control bit 1 is the configuration request and drives cfg_req_o. The engine acknowledge cfg_ack_i is registered once and then reads as bit 7 of both the control and status words, one cycle after the input changes. It stays high after the request is withdrawn until the engine drops it.
- R3: A control write with bit 0 (soft reset) and bit 1 both set clears the transmit requests, the transmit-done flags, the receive flags and the global status, and leaves the configuration request set. Enables, directions and both masks are kept. Bit 0 always reads 0.
- R4: Enable words use 1 = enabled. Direction words use 1 = receive and 0 = transmit. Both are split low/high by mailbox as in the address map.
- R5: The transmit-done words, the receive-flag words and the global status clear on a write of 1 per bit. A written 0 leaves the bit alone. A hardware set in the same cycle as a clear wins.
- R6: Writing 1 to a transmit-request bit sets it only if that mailbox is enabled and set to transmit. A written 0 has no effect. Pending requests appear on tx_req_o.
- R7: A completion strobe for mailbox N clears transmit request N and sets done flag N on the same clock edge.
- R8: A receive strobe for mailbox N sets receive flag N only if N is enabled and set to receive; otherwise it is ignored. If flag N is already set and is not being cleared in that cycle, global status bit 4 (message lost) is set.
- R9: The global status holds 11 event bits (10:0), set by OR-ing in err_evt_i each cycle. Bits 15:11 read 0.
- R10: irq_rx_o is high when any receive flag has its mailbox mask bit set. irq_tx_o does the same for the done flags with the same mask. irq_err_o is high when any global status bit has its global mask bit set.
- R11: Writes to the enable and direction words are ignored unless the registered configuration acknowledge is high.
- R12: Control bit 2 is the sleep request and drives slp_req_o. slp_ack_i is registered and reads as bit 0 of the wake word. A wake write with bit 0 = 0 clears the sleep request; a write with bit 0 = 1 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| cfg_req_o | output | 1 | Configuration-mode request to the engine |
| cfg_ack_i | input | 1 | Engine is in configuration mode |
| slp_req_o | output | 1 | Sleep request to the engine |
| slp_ack_i | input | 1 | Engine is asleep |
| rx_evt_i | input | 1 | Frame received strobe |
| rx_mb_i | input | 5 | Mailbox of the received frame |
| txd_evt_i | input | 1 | Transmission finished strobe |
| txd_mb_i | input | 5 | Mailbox whose transmission finished |
| err_evt_i | input | 11 | Error event strobes into the global status |
| tx_req_o | output | 32 | Pending transmit requests per mailbox |
| irq_rx_o | output | 1 | Receive interrupt |
| irq_tx_o | output | 1 | Transmit interrupt |
| irq_err_o | output | 1 | Error interrupt |

## Verification
Every flag, request and mode bit lives in one register that can be read over the bus, and the interrupt lines are plain OR-reductions of those registers. A wrong internal state therefore shows at the ports on the first read after the edge that wrote it, or at once on an interrupt line whose mask is open. Two cases show up one step later. A missed overrun appears only when the lost-message bit is read or unmasked. A wrongly accepted enable or direction write appears through the transmit-request gating or the receive filtering on the next event for that mailbox. The sequence therefore reads each register back after every stimulus that could have touched it, and watches the interrupt pins after every mask change.

// File: rtl/can_core_pkg.sv
package can_core_pkg;

    localparam int DW       = 16;
    localparam int AW       = 5;
    localparam int MB_N     = 32;
    localparam int HALF_W   = 16;
    localparam int MB_IDX_W = $clog2(MB_N);
    localparam int GEV_N    = 11;

    // bit positions inside the control word
    localparam int CB_SRST  = 0;
    localparam int CB_CFG   = 1;
    localparam int CB_SLP   = 2;
    localparam int CB_ACK   = 7;
    // global status bit raised by a receive overrun
    localparam int GB_LOST  = 4;

    typedef enum logic [AW-1:0] {
        A_CTRL    = 5'd0,
        A_STAT    = 5'd1,
        A_WAKE    = 5'd2,
        A_MBEN_L  = 5'd3,
        A_MBEN_H  = 5'd4,
        A_MBDIR_L = 5'd5,
        A_MBDIR_H = 5'd6,
        A_TXRQ_L  = 5'd7,
        A_TXRQ_H  = 5'd8,
        A_TXDN_L  = 5'd9,
        A_TXDN_H  = 5'd10,
        A_RXF_L   = 5'd11,
        A_RXF_H   = 5'd12,
        A_MBIM_L  = 5'd13,
        A_MBIM_H  = 5'd14,
        A_GSTAT   = 5'd15,
        A_GMASK   = 5'd16
    } reg_addr_e;

    typedef struct packed {
        logic cfg_req;
        logic slp_req;
        logic cfg_ack;
        logic slp_ack;
    } mode_state_t;

    typedef logic [MB_N-1:0] mb_vec_t;

    // replace one 16-bit half of a mailbox vector
    function automatic mb_vec_t half_put(input mb_vec_t cur, input logic hi,
                                         input logic [HALF_W-1:0] d);
        mb_vec_t r;
        r = cur;
        if (hi) r[MB_N-1:HALF_W] = d;
        else    r[HALF_W-1:0]    = d;
        return r;
    endfunction

    function automatic logic [HALF_W-1:0] half_get(input mb_vec_t v, input logic hi);
        return hi ? v[MB_N-1:HALF_W] : v[HALF_W-1:0];
    endfunction

    function automatic mb_vec_t mb_onehot(input logic [MB_IDX_W-1:0] idx);
        mb_vec_t r;
        r = '0;
        r[idx] = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl
    import can_core_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ctrl_we,
    input  logic       wake_we,
    input  logic [2:0] ctrl_bits,
    input  logic       wake_bit,
    input  logic       cfg_ack_i,
    input  logic       slp_ack_i,
    output logic       cfg_req,
    output logic       slp_req,
    output logic       cfg_ack_q,
    output logic       slp_ack_q,
    output logic       soft_rst
);

    mode_state_t st_q, st_n;

    // soft reset is honoured only together with the configuration request
    assign soft_rst = ctrl_we && ctrl_bits[CB_SRST] && ctrl_bits[CB_CFG];

    always_comb begin
        st_n         = st_q;
        st_n.cfg_ack = cfg_ack_i;
        st_n.slp_ack = slp_ack_i;
        if (ctrl_we) begin
            st_n.cfg_req = ctrl_bits[CB_CFG];
            st_n.slp_req = ctrl_bits[CB_SLP];
        end else if (wake_we && !wake_bit) begin
            st_n.slp_req = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_n;
    end

    assign cfg_req   = st_q.cfg_req;
    assign slp_req   = st_q.slp_req;
    assign cfg_ack_q = st_q.cfg_ack;
    assign slp_ack_q = st_q.slp_ack;

    // R2: the engine acknowledge is visible one edge after it arrives
    assert_ack_follow_R2: assert property (@(posedge clk) disable iff (rst)
        cfg_ack_i |=> cfg_ack_q);

    // R12: a wake write with bit 0 low always ends the sleep request
    assert_wake_clear_R12: assert property (@(posedge clk) disable iff (rst)
        (wake_we && !wake_bit && !ctrl_we) |=> !slp_req);

endmodule

// File: rtl/can_mbox_flags.sv
module can_mbox_flags
    import can_core_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [AW-1:0]       addr,
    input  logic [DW-1:0]       wdata,
    input  logic                cfg_ok,
    input  logic                soft_rst,
    input  logic                txd_vld,
    input  logic [MB_IDX_W-1:0] txd_mb,
    input  logic                rx_vld,
    input  logic [MB_IDX_W-1:0] rx_mb,
    input  logic [GEV_N-1:0]    err_evt,
    output mb_vec_t             en_q,
    output mb_vec_t             dir_q,
    output mb_vec_t             txreq_q,
    output mb_vec_t             txdone_q,
    output mb_vec_t             rxf_q,
    output logic [GEV_N-1:0]    gstat_q
);

    mb_vec_t          en_n, dir_n, txreq_n, txdone_n, rxf_n;
    mb_vec_t          tx_set, dn_w1c, rx_w1c, dn_evt, rx_evt;
    logic [GEV_N-1:0] g_w1c, gstat_n;
    logic             rx_lost;

    // write decode: a write of ones into a half produces a set/clear mask
    always_comb begin
        en_n   = en_q;
        dir_n  = dir_q;
        tx_set = '0;
        dn_w1c = '0;
        rx_w1c = '0;
        g_w1c  = '0;
        if (we) begin
            case (addr)
                A_MBEN_L:  if (cfg_ok) en_n  = half_put(en_q, 1'b0, wdata);
                A_MBEN_H:  if (cfg_ok) en_n  = half_put(en_q, 1'b1, wdata);
                A_MBDIR_L: if (cfg_ok) dir_n = half_put(dir_q, 1'b0, wdata);
                A_MBDIR_H: if (cfg_ok) dir_n = half_put(dir_q, 1'b1, wdata);
                A_TXRQ_L:  tx_set = half_put('0, 1'b0, wdata);
                A_TXRQ_H:  tx_set = half_put('0, 1'b1, wdata);
                A_TXDN_L:  dn_w1c = half_put('0, 1'b0, wdata);
                A_TXDN_H:  dn_w1c = half_put('0, 1'b1, wdata);
                A_RXF_L:   rx_w1c = half_put('0, 1'b0, wdata);
                A_RXF_H:   rx_w1c = half_put('0, 1'b1, wdata);
                A_GSTAT:   g_w1c  = wdata[GEV_N-1:0];
                default: ;
            endcase
        end
    end

    // engine events and flag update
    always_comb begin
        dn_evt  = txd_vld ? mb_onehot(txd_mb) : '0;
        rx_evt  = rx_vld ? (mb_onehot(rx_mb) & en_q & dir_q) : '0;
        rx_lost = |(rx_evt & rxf_q & ~rx_w1c);

        txreq_n  = (txreq_q | (tx_set & en_q & ~dir_q)) & ~dn_evt;
        txdone_n = (txdone_q & ~dn_w1c) | dn_evt;
        rxf_n    = (rxf_q & ~rx_w1c) | rx_evt;
        gstat_n  = (gstat_q & ~g_w1c) | err_evt;
        if (rx_lost) gstat_n[GB_LOST] = 1'b1;
    end

    // configuration registers survive the soft reset
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            dir_q <= '0;
        end else begin
            en_q  <= en_n;
            dir_q <= dir_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            txreq_q  <= '0;
            txdone_q <= '0;
            rxf_q    <= '0;
            gstat_q  <= '0;
        end else begin
            txreq_q  <= txreq_n;
            txdone_q <= txdone_n;
            rxf_q    <= rxf_n;
            gstat_q  <= gstat_n;
        end
    end

    // R3: soft reset empties every flag and request
    assert_srst_clear_R3: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (txreq_q == '0 && txdone_q == '0 && rxf_q == '0 && gstat_q == '0));

    // R7: completion drops the request and raises the done flag together
    assert_done_swap_R7: assert property (@(posedge clk) disable iff (rst)
        (txd_vld && !soft_rst) |=> (txdone_q[$past(txd_mb)] && !txreq_q[$past(txd_mb)]));

    // R8: an overrun leaves the lost-message event behind
    assert_overrun_R8: assert property (@(posedge clk) disable iff (rst)
        (rx_lost && !soft_rst) |=> gstat_q[GB_LOST]);

    // R11: mailbox setup is frozen outside configuration mode
    assert_cfg_lock_R11: assert property (@(posedge clk) disable iff (rst)
        !cfg_ok |=> ($stable(en_q) && $stable(dir_q)));

endmodule

// File: rtl/can_irq_gen.sv
module can_irq_gen
    import can_core_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    input  mb_vec_t          rxf,
    input  mb_vec_t          txdone,
    input  logic [GEV_N-1:0] gstat,
    output mb_vec_t          mbim_q,
    output logic [GEV_N-1:0] gmask_q,
    output logic             irq_rx,
    output logic             irq_tx,
    output logic             irq_err
);

    localparam int HALVES = MB_N / HALF_W;

    // one mask half per generate slice
    for (genvar h = 0; h < HALVES; h++) begin : g_mask_half
        localparam logic [AW-1:0] HADDR = AW'(A_MBIM_L) + AW'(h);
        always_ff @(posedge clk) begin
            if (rst)                      mbim_q[h*HALF_W +: HALF_W] <= '0;
            else if (we && addr == HADDR) mbim_q[h*HALF_W +: HALF_W] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                        gmask_q <= '0;
        else if (we && addr == A_GMASK) gmask_q <= wdata[GEV_N-1:0];
    end

    assign irq_rx  = |(rxf & mbim_q);
    assign irq_tx  = |(txdone & mbim_q);
    assign irq_err = |(gstat & gmask_q);

endmodule

// File: rtl/can_ctrl_core.sv
module can_ctrl_core
    import can_core_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic [AW-1:0]       bus_addr,
    input  logic [DW-1:0]       bus_wdata,
    output logic [DW-1:0]       bus_rdata,
    output logic                cfg_req_o,
    input  logic                cfg_ack_i,
    output logic                slp_req_o,
    input  logic                slp_ack_i,
    input  logic                rx_evt_i,
    input  logic [MB_IDX_W-1:0] rx_mb_i,
    input  logic                txd_evt_i,
    input  logic [MB_IDX_W-1:0] txd_mb_i,
    input  logic [GEV_N-1:0]    err_evt_i,
    output logic [MB_N-1:0]     tx_req_o,
    output logic                irq_rx_o,
    output logic                irq_tx_o,
    output logic                irq_err_o
);

    logic             cfg_req, slp_req, cfg_ack_q, slp_ack_q, soft_rst;
    mb_vec_t          en_q, dir_q, txreq_q, txdone_q, rxf_q, mbim_q;
    logic [GEV_N-1:0] gstat_q, gmask_q;
    logic             ctrl_we, wake_we;

    assign ctrl_we = bus_wr && (bus_addr == A_CTRL);
    assign wake_we = bus_wr && (bus_addr == A_WAKE);

    can_mode_ctrl u_mode (
        .clk       (clk),
        .rst       (rst),
        .ctrl_we   (ctrl_we),
        .wake_we   (wake_we),
        .ctrl_bits (bus_wdata[2:0]),
        .wake_bit  (bus_wdata[0]),
        .cfg_ack_i (cfg_ack_i),
        .slp_ack_i (slp_ack_i),
        .cfg_req   (cfg_req),
        .slp_req   (slp_req),
        .cfg_ack_q (cfg_ack_q),
        .slp_ack_q (slp_ack_q),
        .soft_rst  (soft_rst)
    );

    can_mbox_flags u_flags (
        .clk      (clk),
        .rst      (rst),
        .we       (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .cfg_ok   (cfg_ack_q),
        .soft_rst (soft_rst),
        .txd_vld  (txd_evt_i),
        .txd_mb   (txd_mb_i),
        .rx_vld   (rx_evt_i),
        .rx_mb    (rx_mb_i),
        .err_evt  (err_evt_i),
        .en_q     (en_q),
        .dir_q    (dir_q),
        .txreq_q  (txreq_q),
        .txdone_q (txdone_q),
        .rxf_q    (rxf_q),
        .gstat_q  (gstat_q)
    );

    can_irq_gen u_irq (
        .clk     (clk),
        .rst     (rst),
        .we      (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .rxf     (rxf_q),
        .txdone  (txdone_q),
        .gstat   (gstat_q),
        .mbim_q  (mbim_q),
        .gmask_q (gmask_q),
        .irq_rx  (irq_rx_o),
        .irq_tx  (irq_tx_o),
        .irq_err (irq_err_o)
    );

    assign cfg_req_o = cfg_req;
    assign slp_req_o = slp_req;
    assign tx_req_o  = txreq_q;

    // readback; the soft reset bit is write-only
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL: begin
                bus_rdata[CB_CFG] = cfg_req;
                bus_rdata[CB_SLP] = slp_req;
                bus_rdata[CB_ACK] = cfg_ack_q;
            end
            A_STAT:    bus_rdata[CB_ACK] = cfg_ack_q;
            A_WAKE:    bus_rdata[0]      = slp_ack_q;
            A_MBEN_L:  bus_rdata = half_get(en_q, 1'b0);
            A_MBEN_H:  bus_rdata = half_get(en_q, 1'b1);
            A_MBDIR_L: bus_rdata = half_get(dir_q, 1'b0);
            A_MBDIR_H: bus_rdata = half_get(dir_q, 1'b1);
            A_TXRQ_L:  bus_rdata = half_get(txreq_q, 1'b0);
            A_TXRQ_H:  bus_rdata = half_get(txreq_q, 1'b1);
            A_TXDN_L:  bus_rdata = half_get(txdone_q, 1'b0);
            A_TXDN_H:  bus_rdata = half_get(txdone_q, 1'b1);
            A_RXF_L:   bus_rdata = half_get(rxf_q, 1'b0);
            A_RXF_H:   bus_rdata = half_get(rxf_q, 1'b1);
            A_MBIM_L:  bus_rdata = half_get(mbim_q, 1'b0);
            A_MBIM_H:  bus_rdata = half_get(mbim_q, 1'b1);
            A_GSTAT:   bus_rdata[GEV_N-1:0] = gstat_q;
            A_GMASK:   bus_rdata[GEV_N-1:0] = gmask_q;
            default: ;
        endcase
    end

    // R10: the error line implies some pending global event
    assert_err_src_R10: assert property (@(posedge clk) disable iff (rst)
        irq_err_o |-> (gstat_q != '0));

    // R6: a fresh request can only appear on an enabled transmit mailbox
    assert_txreq_gate_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_req_o[0]) |-> (en_q[0] && !dir_q[0]));

endmodule

// File: tb/can_ctrl_core_tb_top.sv
module can_ctrl_core_tb_top;
    import can_core_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_wr = 1'b0;
    logic [AW-1:0]     bus_addr = '0;
    logic [DW-1:0]     bus_wdata = '0;
    logic [DW-1:0]     bus_rdata;
    logic              cfg_req_o, slp_req_o;
    logic              cfg_ack_i = 1'b0, slp_ack_i = 1'b0;
    logic              rx_evt_i = 1'b0, txd_evt_i = 1'b0;
    logic [MB_IDX_W-1:0] rx_mb_i = '0, txd_mb_i = '0;
    logic [GEV_N-1:0]  err_evt_i = '0;
    logic [MB_N-1:0]   tx_req_o;
    logic              irq_rx_o, irq_tx_o, irq_err_o;

    int checks = 0;
    int errors = 0;

    // scoreboard queues: expected value, selector (bit 5 = pin group), tag
    logic [15:0] q_exp[$];
    logic [5:0]  q_sel[$];
    string       q_tag[$];

    always #4 clk = ~clk; // 125 MHz

    can_ctrl_core dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cfg_req_o(cfg_req_o), .cfg_ack_i(cfg_ack_i),
        .slp_req_o(slp_req_o), .slp_ack_i(slp_ack_i),
        .rx_evt_i(rx_evt_i), .rx_mb_i(rx_mb_i),
        .txd_evt_i(txd_evt_i), .txd_mb_i(txd_mb_i),
        .err_evt_i(err_evt_i), .tx_req_o(tx_req_o),
        .irq_rx_o(irq_rx_o), .irq_tx_o(irq_tx_o), .irq_err_o(irq_err_o)
    );

    // pin group: bit4 cfg_req, bit3 slp_req, bit2 irq_rx, bit1 irq_tx, bit0 irq_err
    wire [15:0] pins = {11'b0, cfg_req_o, slp_req_o, irq_rx_o, irq_tx_o, irq_err_o};

    // monitor: compares queued expectations away from the rising edge
    always @(negedge clk) begin
        while (q_exp.size() > 0) begin
            logic [15:0] e, a;
            logic [5:0]  s;
            string       t;
            e = q_exp.pop_front();
            s = q_sel.pop_front();
            t = q_tag.pop_front();
            a = s[5] ? pins : bus_rdata;
            checks++;
            if (a !== e) begin
                errors++;
                $display("FAIL %s sel=%0d actual=%h expected=%h", t, s, a, e);
            end
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic chk_reg(input logic [AW-1:0] a, input logic [15:0] e, input string t);
        bus_addr = a;
        q_exp.push_back(e); q_sel.push_back({1'b0, a}); q_tag.push_back(t);
        @(negedge clk); #1;
    endtask

    task automatic chk_pins(input logic [15:0] e, input string t);
        q_exp.push_back(e); q_sel.push_back(6'h20); q_tag.push_back(t);
        @(negedge clk); #1;
    endtask

    task automatic set_cfg_ack(input logic v);
        @(posedge clk); #1; cfg_ack_i = v;
        @(posedge clk); #1;
    endtask

    task automatic set_slp_ack(input logic v);
        @(posedge clk); #1; slp_ack_i = v;
        @(posedge clk); #1;
    endtask

    task automatic rx_pulse(input logic [MB_IDX_W-1:0] mb);
        @(posedge clk); #1; rx_evt_i = 1'b1; rx_mb_i = mb;
        @(posedge clk); #1; rx_evt_i = 1'b0;
    endtask

    task automatic txd_pulse(input logic [MB_IDX_W-1:0] mb);
        @(posedge clk); #1; txd_evt_i = 1'b1; txd_mb_i = mb;
        @(posedge clk); #1; txd_evt_i = 1'b0;
    endtask

    task automatic err_pulse(input logic [GEV_N-1:0] ev);
        @(posedge clk); #1; err_evt_i = ev;
        @(posedge clk); #1; err_evt_i = '0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 reset state
        chk_reg(A_CTRL, 16'h0000, "R1 ctrl");
        chk_reg(A_STAT, 16'h0000, "R1 stat");
        chk_reg(A_GSTAT, 16'h0000, "R1 gstat");
        chk_pins(16'h0000, "R1 pins");
        // R11 setup write outside configuration
        wr(A_MBEN_L, 16'h00FF);
        chk_reg(A_MBEN_L, 16'h0000, "R11 enable locked");
        // R2 enter configuration
        wr(A_CTRL, 16'h0002);
        chk_pins(16'h0010, "R2 cfg_req pin");
        chk_reg(A_CTRL, 16'h0002, "R2 no ack yet");
        set_cfg_ack(1'b1);
        chk_reg(A_CTRL, 16'h0082, "R2 ack in ctrl");
        chk_reg(A_STAT, 16'h0080, "R2 ack in stat");
        // R4 mailbox setup: mb0, mb4 rx; mb24 tx
        wr(A_MBEN_L, 16'h0011);
        wr(A_MBEN_H, 16'h0100);
        wr(A_MBDIR_L, 16'hFFFF);
        wr(A_MBDIR_H, 16'h0000);
        chk_reg(A_MBEN_L, 16'h0011, "R4 enable low");
        chk_reg(A_MBEN_H, 16'h0100, "R4 enable high");
        chk_reg(A_MBDIR_L, 16'hFFFF, "R4 direction low");
        // R2 leave configuration, ack lingers until engine drops it
        wr(A_CTRL, 16'h0000);
        chk_pins(16'h0000, "R2 cfg_req dropped");
        chk_reg(A_STAT, 16'h0080, "R2 ack lingers");
        set_cfg_ack(1'b0);
        chk_reg(A_STAT, 16'h0000, "R2 ack gone");
        wr(A_MBDIR_L, 16'h0000);
        chk_reg(A_MBDIR_L, 16'hFFFF, "R11 direction locked");
        // R6 transmit request gating
        wr(A_TXRQ_H, 16'h0101);
        chk_reg(A_TXRQ_H, 16'h0100, "R6 only enabled tx mailbox");
        wr(A_TXRQ_L, 16'h0001);
        chk_reg(A_TXRQ_L, 16'h0000, "R6 receive mailbox refused");
        wr(A_TXRQ_H, 16'h0000);
        chk_reg(A_TXRQ_H, 16'h0100, "R6 zero write no effect");
        if (tx_req_o !== 32'h0100_0000) begin
            errors++;
            $display("FAIL R6 tx_req_o actual=%h expected=%h", tx_req_o, 32'h0100_0000);
        end
        checks++;
        // R7 completion
        txd_pulse(5'd24);
        chk_reg(A_TXRQ_H, 16'h0000, "R7 request cleared");
        chk_reg(A_TXDN_H, 16'h0100, "R7 done set");
        chk_pins(16'h0000, "R10 tx masked");
        wr(A_MBIM_H, 16'h0100);
        chk_pins(16'h0002, "R10 tx irq");
        // R5 write-one-to-clear
        wr(A_TXDN_H, 16'h0000);
        chk_reg(A_TXDN_H, 16'h0100, "R5 zero keeps done");
        wr(A_TXDN_H, 16'h0100);
        chk_reg(A_TXDN_H, 16'h0000, "R5 one clears done");
        chk_pins(16'h0000, "R10 tx irq gone");
        // R8 receive filtering and overrun
        rx_pulse(5'd0);
        chk_reg(A_RXF_L, 16'h0001, "R8 rx flag set");
        rx_pulse(5'd1);
        chk_reg(A_RXF_L, 16'h0001, "R8 disabled mailbox ignored");
        rx_pulse(5'd24);
        chk_reg(A_RXF_H, 16'h0000, "R8 tx mailbox ignored");
        wr(A_MBIM_L, 16'h0001);
        chk_pins(16'h0004, "R10 rx irq");
        rx_pulse(5'd0);
        chk_reg(A_GSTAT, 16'h0010, "R8 lost message");
        chk_pins(16'h0004, "R10 err masked");
        wr(A_GMASK, 16'h0010);
        chk_pins(16'h0005, "R10 err irq");
        // R9 global events
        err_pulse(11'h7FF);
        chk_reg(A_GSTAT, 16'h07FF, "R9 all events");
        wr(A_GSTAT, 16'hFFFF & 16'h0015);
        chk_reg(A_GSTAT, 16'h07EA, "R5 gstat w1c");
        chk_pins(16'h0004, "R10 err cleared source");
        wr(A_GMASK, 16'h0002);
        chk_pins(16'h0005, "R10 err other bit");
        // R5 set wins against clear in the same cycle, no overrun
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = A_RXF_L; bus_wdata = 16'h0001;
        rx_evt_i = 1'b1; rx_mb_i = 5'd0;
        @(posedge clk); #1;
        bus_wr = 1'b0; rx_evt_i = 1'b0;
        chk_reg(A_RXF_L, 16'h0001, "R5 set wins");
        chk_reg(A_GSTAT, 16'h07EA, "R8 no loss when cleared");
        // R12 sleep handshake
        wr(A_CTRL, 16'h0004);
        chk_pins(16'h000D, "R12 slp_req pin");
        set_slp_ack(1'b1);
        chk_reg(A_WAKE, 16'h0001, "R12 sleep ack");
        wr(A_WAKE, 16'h0001);
        chk_pins(16'h000D, "R12 one write ignored");
        wr(A_WAKE, 16'h0000);
        chk_pins(16'h0005, "R12 wake clears request");
        chk_reg(A_CTRL, 16'h0000, "R12 ctrl after wake");
        set_slp_ack(1'b0);
        // R3 soft reset
        wr(A_TXRQ_H, 16'h0100);
        chk_reg(A_TXRQ_H, 16'h0100, "R3 pre request");
        wr(A_CTRL, 16'h0003);
        chk_reg(A_CTRL, 16'h0002, "R3 ctrl after reset");
        chk_reg(A_TXRQ_H, 16'h0000, "R3 request cleared");
        chk_reg(A_RXF_L, 16'h0000, "R3 rx cleared");
        chk_reg(A_GSTAT, 16'h0000, "R3 gstat cleared");
        chk_reg(A_MBEN_L, 16'h0011, "R3 enable kept");
        chk_reg(A_MBIM_L, 16'h0001, "R3 mask kept");
        chk_pins(16'h0010, "R3 pins");
        repeat (2) @(posedge clk);
        summary();
        $finish;
    end

endmodule